// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns one asynchronous serial input line into parallel words. It runs from an oversampling enable pulse (`tick_en`) that an external baud generator provides. The block does no work in cycles where that pulse is low. The raw line first goes through a majority-style digital noise filter. After the filter, a frame sequencer finds the start bit and samples each data, parity and stop bit at its centre. It then hands a finished word, with its own error flags, to a one-word result holder.

Run-time inputs set the frame shape and the sampling behaviour:
- data length of 7, 8 or 9 bits;
- parity: none, even or odd;
- one or two stop bits;
- start detection on a low level or on a falling edge;
- normal or double-speed oversampling.

The frame sequencer takes a copy of these settings when it accepts a start bit, so a frame always keeps the shape it began with. The filtered line level goes straight out to a pin, so that a long low level following a framing error can be recognised as a break. The consumer takes a word by pulsing `rd_ack`. A word that arrives before the previous one has been taken is dropped, and the drop is reported as an overrun.

Top module: `serial_rx_core`

## Requirements
- R1: The filtered line (`line_filt`) changes only on a tick. It takes a new level only after the last three tick samples of `rx_line` all equal that level. A low pulse lasting fewer than three ticks never reaches `line_filt` and starts no frame.
- R2: `cfg_len` selects the data length: 0 or 3 gives 8 bits, 1 gives 7 bits, 2 gives 9 bits. Data bits arrive LSB first, and a 9th bit follows the 8th. The word is right-aligned on `rx_data`, and the unused upper bits read as zero.
- R3: `cfg_parity` selects the parity: 0 or 3 gives none, 1 gives even, 2 gives odd. The parity bit follows the last data bit. `err_parity` is set with the word when the count of ones over data plus parity disagrees with the selected mode. It is never set when parity is off.
- R4: `cfg_two_stop` selects one (0) or two (1) stop bits. `err_framing` is set with the word when any checked stop bit is sampled low.
- R5: When a frame completes while `rx_valid` is high and `rd_ack` is low, `err_overrun` rises on the next cycle. The held word and its flags stay unchanged. Otherwise a completed frame loads `rx_data` and its flags and raises `rx_valid` on the next cycle.
- R6: A `rd_ack` pulse with no frame completing in the same cycle clears `rx_valid`, `err_parity`, `err_framing` and `err_overrun` on the next cycle. If a frame completes in the same cycle as `rd_ack`, the new word is loaded with no overrun.
- R7: With `cfg_edge_start`=0, an idle receiver starts a frame on any tick that sees `line_filt` low. With `cfg_edge_start`=1, a frame starts only on a high-to-low change of `line_filt`, so a line that stays low after a frame starts nothing.
- R8: A bit lasts 16 ticks when `cfg_double`=0 and 8 ticks when `cfg_double`=1. Each bit is sampled at its centre.
- R9: If `line_filt` is high again at the centre of the start bit, the frame is abandoned and no word is produced.
- R10: `line_filt` always shows the filtered line level. A break (line held low across a whole frame) produces a word of zeros with `err_framing` set, while `line_filt` reads low.
- R11: After reset `rx_valid`, all error flags and `rx_data` are zero, and `line_filt` is high.
- R12: The length, parity, stop-bit and speed settings are captured when the start bit is accepted. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Oversampling enable pulse from the baud generator |
| rx_line | input | 1 | Raw serial input line, idle high |
| cfg_len | input | 2 | Data length select (R2) |
| cfg_parity | input | 2 | Parity mode select (R3) |
| cfg_two_stop | input | 1 | Two stop bits when high |
| cfg_edge_start | input | 1 | Start detection on falling edge when high, on low level when low |
| cfg_double | input | 1 | Double-speed oversampling (8 ticks per bit) |
| rd_ack | input | 1 | Consumer takes the held word |
| rx_data | output | 9 | Received word, right-aligned |
| rx_valid | output | 1 | A word is held and not yet taken |
| err_parity | output | 1 | Parity error for the held word |
| err_framing | output | 1 | Stop-bit error for the held word |
| err_overrun | output | 1 | A frame was dropped because the held word was not taken |
| line_filt | output | 1 | Filtered line level |

## Verification
The hardest cases to reach are the ones that depend on what the line does after a frame ends. These are the break that never releases the line, and the different restart behaviour of level and edge start detection while the line stays low. The stimulus holds the line low for more than a frame in edge mode. It confirms that exactly one framing-error word of zeros appears and that nothing follows it. It then switches to level mode with the line still low and expects a fresh frame to start on its own. Overrun is reached by sending two back-to-back frames without acknowledging, and the start-bit abort is reached with a low pulse long enough to pass the filter but short of the bit centre.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

    typedef enum logic [1:0] {
        LEN_8     = 2'd0,
        LEN_7     = 2'd1,
        LEN_9     = 2'd2,
        LEN_8_ALT = 2'd3
    } len_e;

    typedef enum logic [1:0] {
        PAR_NONE     = 2'd0,
        PAR_EVEN     = 2'd1,
        PAR_ODD      = 2'd2,
        PAR_NONE_ALT = 2'd3
    } par_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    localparam int WORD_W = 9;

    // Frame shape captured at start-bit acceptance
    typedef struct packed {
        len_e par_len_unused_guard_len;
        par_e par;
        logic two_stop;
        logic dbl;
    } rx_cfg_t;

    // Result of one frame
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_word_t;

    function automatic logic [3:0] bits_of(input len_e len);
        case (len)
            LEN_7:   return 4'd7;
            LEN_9:   return 4'd9;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic parity_on(input par_e p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    // Shift register fills from the top; move the word down to bit 0
    function automatic logic [WORD_W-1:0] align_word(input logic [WORD_W-1:0] sh,
                                                     input len_e len);
        case (len)
            LEN_7:   return {2'b00, sh[WORD_W-1:2]};
            LEN_9:   return sh;
            default: return {1'b0, sh[WORD_W-1:1]};
        endcase
    endfunction

    function automatic logic parity_bad(input logic [WORD_W-1:0] d,
                                        input logic pbit, input par_e p);
        case (p)
            PAR_EVEN: return (^d) ^ pbit;
            PAR_ODD:  return ~((^d) ^ pbit);
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/serrx_filter.sv
module serrx_filter #(
    parameter int VOTES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic din,
    output logic dout
);
    logic [VOTES-1:0] hist;
    logic [VOTES-1:0] hist_nxt;

    assign hist_nxt = {hist[VOTES-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '1;
            dout <= 1'b1;
        end else if (tick) begin
            hist <= hist_nxt;
            if (&hist_nxt) begin
                dout <= 1'b1;
            end else if (~|hist_nxt) begin
                dout <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/serrx_sampler.sv
module serrx_sampler
    import serrx_pkg::*;
#(
    parameter int NORM_TICKS = 16,
    parameter int FAST_TICKS = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     line,
    input  rx_cfg_t  cfg_in,
    input  logic     edge_start,
    output logic     done,
    output rx_word_t word,
    output len_e     frame_len
);
    localparam int CW = $clog2(NORM_TICKS);
    localparam logic [CW-1:0] NORM_LAST = CW'(NORM_TICKS - 1);
    localparam logic [CW-1:0] NORM_MID  = CW'(NORM_TICKS / 2 - 1);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_TICKS - 1);
    localparam logic [CW-1:0] FAST_MID  = CW'(FAST_TICKS / 2 - 1);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [3:0]        bidx;
    logic [WORD_W-1:0] shreg;
    logic              pbit;
    logic              ferr_acc;
    logic              line_q;
    rx_cfg_t           cfg_q;

    logic [CW-1:0]     lim_full;
    logic [CW-1:0]     lim_mid;
    logic [3:0]        nbits;
    logic              start_seen;
    logic              at_full;
    rx_word_t          word_nxt;

    always_comb begin
        lim_full   = cfg_q.dbl ? FAST_LAST : NORM_LAST;
        lim_mid    = cfg_q.dbl ? FAST_MID  : NORM_MID;
        nbits      = bits_of(cfg_q.par_len_unused_guard_len);
        start_seen = edge_start ? (line_q & ~line) : ~line;
        at_full    = (cnt == lim_full);
        word_nxt.data = align_word(shreg, cfg_q.par_len_unused_guard_len);
        word_nxt.perr = parity_bad(word_nxt.data, pbit, cfg_q.par);
        word_nxt.ferr = ferr_acc | ~line;
    end

    assign frame_len = cfg_q.par_len_unused_guard_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            pbit     <= 1'b0;
            ferr_acc <= 1'b0;
            line_q   <= 1'b1;
            cfg_q    <= '{par_len_unused_guard_len: LEN_8, par: PAR_NONE,
                          two_stop: 1'b0, dbl: 1'b0};
            done     <= 1'b0;
            word     <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                line_q <= line;
                case (state)
                    ST_IDLE: begin
                        if (start_seen) begin
                            cfg_q    <= cfg_in;
                            cnt      <= '0;
                            ferr_acc <= 1'b0;
                            state    <= ST_START;
                        end
                    end
                    ST_START: begin
                        if (cnt == lim_mid) begin
                            cnt  <= '0;
                            bidx <= '0;
                            state <= line ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_full) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[WORD_W-1:1]};
                            if (bidx == nbits - 4'd1) begin
                                state <= parity_on(cfg_q.par) ? ST_PAR : ST_STOP1;
                            end else begin
                                bidx <= bidx + 4'd1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (at_full) begin
                            cnt   <= '0;
                            pbit  <= line;
                            state <= ST_STOP1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP1: begin
                        if (at_full) begin
                            cnt <= '0;
                            if (cfg_q.two_stop) begin
                                ferr_acc <= ~line;
                                state    <= ST_STOP2;
                            end else begin
                                word  <= word_nxt;
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP2: begin
                        if (at_full) begin
                            cnt   <= '0;
                            word  <= word_nxt;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/serrx_holder.sv
module serrx_holder
    import serrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_word_t          word,
    input  logic              ack,
    output logic [WORD_W-1:0] data,
    output logic              valid,
    output logic              perr,
    output logic              ferr,
    output logic              ovr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            valid <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            ovr   <= 1'b0;
        end else if (done && valid && !ack) begin
            ovr <= 1'b1;
        end else if (done) begin
            data  <= word.data;
            perr  <= word.perr;
            ferr  <= word.ferr;
            valid <= 1'b1;
            ovr   <= 1'b0;
        end else if (ack) begin
            valid <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            ovr   <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serrx_pkg::*;
#(
    parameter int NORM_TICKS = 16,
    parameter int FAST_TICKS = 8,
    parameter int VOTES      = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       rx_line,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_parity,
    input  logic       cfg_two_stop,
    input  logic       cfg_edge_start,
    input  logic       cfg_double,
    input  logic       rd_ack,
    output logic [8:0] rx_data,
    output logic       rx_valid,
    output logic       err_parity,
    output logic       err_framing,
    output logic       err_overrun,
    output logic       line_filt
);
    rx_cfg_t  cfg_now;
    rx_word_t done_word;
    logic     frame_done;
    len_e     active_len;

    always_comb begin
        cfg_now.par_len_unused_guard_len = len_e'(cfg_len);
        cfg_now.par      = par_e'(cfg_parity);
        cfg_now.two_stop = cfg_two_stop;
        cfg_now.dbl      = cfg_double;
    end

    serrx_filter #(.VOTES(VOTES)) filt_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_en),
        .din  (rx_line),
        .dout (line_filt)
    );

    serrx_sampler #(.NORM_TICKS(NORM_TICKS), .FAST_TICKS(FAST_TICKS)) samp_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_en),
        .line       (line_filt),
        .cfg_in     (cfg_now),
        .edge_start (cfg_edge_start),
        .done       (frame_done),
        .word       (done_word),
        .frame_len  (active_len)
    );

    serrx_holder hold_i (
        .clk   (clk),
        .rst   (rst),
        .done  (frame_done),
        .word  (done_word),
        .ack   (rd_ack),
        .data  (rx_data),
        .valid (rx_valid),
        .perr  (err_parity),
        .ferr  (err_framing),
        .ovr   (err_overrun)
    );
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_en,
    input logic       rx_line,
    input logic       rd_ack,
    input logic       rx_valid,
    input logic [8:0] rx_data,
    input logic       err_parity,
    input logic       err_framing,
    input logic       err_overrun,
    input logic       line_filt,
    input logic       frame_done,
    input logic [8:0] done_data,
    input logic [1:0] done_len
);
    // R1: filtered level moves only on a tick, toward the sampled level
    assert_filter_tick_R1: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_filt) |-> ($past(tick_en) && ($past(rx_line) == line_filt)));

    // R2: a 7-bit word leaves its two upper bits clear
    assert_len_mask_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_done && done_len == 2'd1) |-> (done_data[8:7] == 2'b00));

    // R3 / R4: error flags only describe a held word
    assert_flags_need_word_R3: assert property (@(posedge clk) disable iff (rst)
        (err_parity || err_framing || err_overrun) |-> rx_valid);

    // R5: a held word does not change until taken
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rd_ack) |=> (rx_valid && $stable(rx_data)));

    // R5: completion on a held word raises overrun
    assert_overrun_set_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_done && rx_valid && !rd_ack) |=> err_overrun);

    // R5: completion on a free holder loads the word
    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !(rx_valid && !rd_ack)) |=>
        (rx_valid && !err_overrun && rx_data == $past(done_data)));

    // R6: acknowledge empties the holder
    assert_ack_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !frame_done) |=> (!rx_valid && !err_overrun && !err_parity && !err_framing));
endmodule

bind serial_rx_core serial_rx_core_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .tick_en     (tick_en),
    .rx_line     (rx_line),
    .rd_ack      (rd_ack),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .err_parity  (err_parity),
    .err_framing (err_framing),
    .err_overrun (err_overrun),
    .line_filt   (line_filt),
    .frame_done  (frame_done),
    .done_data   (done_word.data),
    .done_len    (active_len)
);

// File: tb/serial_rx_core_tb.sv
`timescale 1ns/1ps
module serial_rx_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_len = 2'd0;
    logic [1:0] cfg_parity = 2'd0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_edge_start = 1'b0;
    logic       cfg_double = 1'b0;
    logic       rd_ack = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid;
    logic       err_parity;
    logic       err_framing;
    logic       err_overrun;
    logic       line_filt;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    int filt_low_cycles = 0;
    int valid_cycles = 0;
    int tick_div = 0;

    always #5 clk = ~clk;

    serial_rx_core dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rx_line(rx_line),
        .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .cfg_edge_start(cfg_edge_start), .cfg_double(cfg_double), .rd_ack(rd_ack),
        .rx_data(rx_data), .rx_valid(rx_valid), .err_parity(err_parity),
        .err_framing(err_framing), .err_overrun(err_overrun), .line_filt(line_filt)
    );

    // tick every third cycle, changed away from the active edge
    always @(negedge clk) begin
        tick_div <= (tick_div == 2) ? 0 : tick_div + 1;
        tick_en  <= (tick_div == 2);
        if (!line_filt) filt_low_cycles <= filt_low_cycles + 1;
        if (rx_valid)   valid_cycles    <= valid_cycles + 1;
    end

    typedef struct packed {
        logic [1:0] len;
        logic [1:0] par;
        logic       two;
        logic       dbl;
        logic [8:0] data;
        logic       bad_par;
        logic       bad_s1;
        logic       bad_s2;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b0, 1'b0},
        '{2'd1, 2'd0, 1'b0, 1'b0, 9'h15B, 1'b0, 1'b0, 1'b0},
        '{2'd2, 2'd0, 1'b0, 1'b0, 9'h1C3, 1'b0, 1'b0, 1'b0},
        '{2'd0, 2'd1, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b0, 1'b0},
        '{2'd0, 2'd2, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b0, 1'b0},
        '{2'd0, 2'd1, 1'b0, 1'b0, 9'h0E1, 1'b1, 1'b0, 1'b0},
        '{2'd2, 2'd2, 1'b1, 1'b0, 9'h101, 1'b0, 1'b0, 1'b0},
        '{2'd1, 2'd1, 1'b1, 1'b1, 9'h07F, 1'b0, 1'b0, 1'b0},
        '{2'd0, 2'd0, 1'b0, 1'b0, 9'h066, 1'b0, 1'b1, 1'b0},
        '{2'd3, 2'd3, 1'b1, 1'b0, 9'h099, 1'b0, 1'b0, 1'b1},
        '{2'd0, 2'd2, 1'b0, 1'b1, 9'h000, 1'b1, 1'b0, 1'b0},
        '{2'd2, 2'd1, 1'b1, 1'b1, 9'h1FF, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick_en) @(posedge clk);
        end
    endtask

    task automatic drive_bit(input logic b, input int t);
        @(negedge clk);
        rx_line = b;
        wait_ticks(t);
    endtask

    task automatic ack_word();
        @(negedge clk);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    function automatic int nbits_of(input logic [1:0] len);
        return (len == 2'd1) ? 7 : (len == 2'd2) ? 9 : 8;
    endfunction

    function automatic logic [8:0] exp_data(input logic [8:0] d, input logic [1:0] len);
        return d & ((9'h1 << nbits_of(len)) - 9'h1);
    endfunction

    function automatic logic par_enabled(input logic [1:0] p);
        return (p == 2'd1) || (p == 2'd2);
    endfunction

    task automatic send_frame(input logic [1:0] len, input logic [1:0] par,
                              input logic two, input logic dbl, input logic [8:0] d,
                              input logic bp, input logic bs1, input logic bs2,
                              input logic swap_mid);
        int t;
        int n;
        logic pb;
        t = dbl ? 8 : 16;
        n = nbits_of(len);
        @(negedge clk);
        cfg_len = len; cfg_parity = par; cfg_two_stop = two; cfg_double = dbl;
        drive_bit(1'b0, t);
        if (swap_mid) begin
            @(negedge clk);
            cfg_len = 2'd1; cfg_parity = 2'd1; cfg_two_stop = 1'b1; cfg_double = 1'b1;
        end
        for (int i = 0; i < n; i++) drive_bit(d[i], t);
        if (par_enabled(par)) begin
            pb = (par == 2'd1) ? ^exp_data(d, len) : ~^exp_data(d, len);
            drive_bit(pb ^ bp, t);
        end
        drive_bit(~bs1, t);
        if (two) drive_bit(~bs2, t);
        drive_bit(1'b1, 2 * t);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int fl0;
        int vc0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 valid", rx_valid, 0);
        check("R11 flags", {err_parity, err_framing, err_overrun}, 0);
        check("R11 data", rx_data, 0);
        check("R11 line_filt", line_filt, 1);
        wait_ticks(8);

        // table walk: R2 R3 R4 R8 (level start)
        for (int v = 0; v < NV; v++) begin
            send_frame(VECS[v].len, VECS[v].par, VECS[v].two, VECS[v].dbl, VECS[v].data,
                       VECS[v].bad_par, VECS[v].bad_s1, VECS[v].bad_s2, 1'b0);
            @(negedge clk);
            check("R8 valid", rx_valid, 1);
            check("R2 data", rx_data, exp_data(VECS[v].data, VECS[v].len));
            check("R3 parity", err_parity, par_enabled(VECS[v].par) && VECS[v].bad_par);
            check("R4 framing", err_framing, VECS[v].bad_s1 || (VECS[v].two && VECS[v].bad_s2));
            ack_word();
            check("R6 ack clears", {rx_valid, err_parity, err_framing}, 0);
        end

        // R1: two-tick glitch is filtered out
        fl0 = filt_low_cycles; vc0 = valid_cycles;
        drive_bit(1'b0, 2);
        drive_bit(1'b1, 60);
        check("R1 glitch filt", filt_low_cycles - fl0, 0);
        check("R1 glitch word", valid_cycles - vc0, 0);

        // R9: false start, low 5 ticks at 16 ticks per bit
        fl0 = filt_low_cycles; vc0 = valid_cycles;
        cfg_double = 1'b0;
        drive_bit(1'b0, 5);
        drive_bit(1'b1, 16 * 14);
        check("R9 filt saw low", (filt_low_cycles - fl0) > 0, 1);
        check("R9 no word", valid_cycles - vc0, 0);

        // R5 overrun keeps the first word
        send_frame(2'd0, 2'd0, 1'b0, 1'b0, 9'h05A, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(2'd0, 2'd0, 1'b0, 1'b0, 9'h0C3, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R5 overrun flag", err_overrun, 1);
        check("R5 old word kept", rx_data, 9'h05A);
        check("R5 still valid", rx_valid, 1);
        ack_word();
        check("R6 overrun cleared", {rx_valid, err_overrun}, 0);

        // R12 settings captured at start bit
        send_frame(2'd0, 2'd0, 1'b0, 1'b0, 9'h0C6, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R12 data", rx_data, 9'h0C6);
        check("R12 no errors", {err_parity, err_framing}, 0);
        ack_word();
        cfg_len = 2'd0; cfg_parity = 2'd0; cfg_two_stop = 1'b0; cfg_double = 1'b0;

        // R10 / R7 break in edge mode
        cfg_edge_start = 1'b1;
        wait_ticks(16);
        drive_bit(1'b0, 16 * 14);
        @(negedge clk);
        check("R10 break valid", rx_valid, 1);
        check("R10 break framing", err_framing, 1);
        check("R10 break data", rx_data, 0);
        check("R10 line_filt low", line_filt, 0);
        ack_word();
        vc0 = valid_cycles;
        wait_ticks(16 * 14);
        check("R7 edge no restart", valid_cycles - vc0, 0);

        // R7 level mode restarts while line stays low
        cfg_edge_start = 1'b0;
        wait_ticks(16 * 14);
        @(negedge clk);
        check("R7 level restart", rx_valid, 1);
        check("R7 level framing", err_framing, 1);
        ack_word();
        drive_bit(1'b1, 16 * 30);
        ack_word();
        wait_ticks(16 * 2);

        // R7 edge mode still receives a normal frame
        cfg_edge_start = 1'b1;
        send_frame(2'd2, 2'd2, 1'b0, 1'b0, 9'h13A, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R7 edge frame data", rx_data, 9'h13A);
        check("R7 edge frame flags", {rx_valid, err_parity, err_framing, err_overrun}, 4'b1000);
        ack_word();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule